// File: doc/BRIEF.md
# Per-Bit Pattern Match Detector

This block watches an 8-bit input port and raises a sticky match flag when the port meets a pattern that software programs bit by bit. Each bit of the port can be left out, or it can be required to sit at a level, or to make an edge between two consecutive samples. The results of the individual bits are then combined by one of three rules: every selected bit must hold, any selected bit may hold, or any may hold while the highest-numbered bit that holds is reported on a priority output.

The port is synchronized with two flops. Each new sample is compared with the sample one clock earlier to find edges. An optional latch freezes the port value seen at the match sample until software reads the data register. An interrupt request follows the match flag. Unless the interrupt is limited to matches, it also follows a flag that marks any change of the port value. Software works through a simple register interface: one write port, and one read port whose data is combinational.

Top module: `pattern_match_unit`

## Requirements
- R1: After reset, match_flag, irq and prio_idx are 0, and every register reads 0.
- R2: Each bit has a 3-bit code {mask, transition, polarity}. The code 00x leaves the bit out, 100 requires the bit low and 101 requires it high. A port change is seen by the match logic two clocks after it is applied, and match_flag rises one clock after that.
- R3: The code 110 requires a falling edge and 111 requires a rising edge, each between the current sample and the previous one. The code 01x requires any change. An edge counts for a single sample only.
- R4: With rule 1 (mode bits 2:1 = 1), a match needs every selected bit to hold on the same sample.
- R5: With rule 2 (mode bits 2:1 = 2), a match needs any selected bit to hold.
- R6: With rule 3 (mode bits 2:1 = 3), a match needs any selected bit to hold, and on each match prio_idx takes the highest bit number that holds. prio_idx changes at no other time.
- R7: With rule 0, or with every bit left out, no match is ever reported.
- R8: When mode bit 0 is set, the port value at the first match sample is held. Reads of the data register (address 5) return the held value, and the first such read releases the hold. Without a hold, reads of address 5 return the current synchronized sample.
- R9: match_flag stays set until software writes 1 to status bit 1 (address 4). If a match occurs in the same cycle as that write, the flag stays set.
- R10: Status bit 2 is set whenever the sample changes and is cleared by writing 1 to it. irq equals match_flag when mode bit 3 is set. Otherwise irq is match_flag OR status bit 2.
- R11: The registers read back at these addresses: 0 mode (4 bits), 1 mask, 2 transition, 3 polarity, 4 status, 5 data. The status byte reads match_flag in bit 1 and the change flag in bit 2, with its other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Asynchronous input port being watched |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (side effect on data reads only) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| match_flag | output | 1 | Sticky pattern match flag |
| irq | output | 1 | Interrupt request |
| prio_idx | output | 3 | Highest matching bit number in rule 3 |

## Verification
The bench drives level patterns on a single bit while other bits change freely. This shows that left-out bits are ignored and that low and high polarities are handled as separate cases. Falling, rising and any-change codes are driven in both directions, and each edge is held for several cycles. This separates a true edge detector from a level detector and shows that an edge counts once. The rule tests pair a partial pattern with a full one, so AND can be told apart from OR. Several bits are set at once to check that the priority output picks the highest bit. A capture followed by a port change and two reads separates the held value from the live one.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    RULE_OFF  = 2'd0,
    RULE_ALL  = 2'd1,
    RULE_ANY  = 2'd2,
    RULE_PRIO = 2'd3
  } pm_rule_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRANS = 3'd2;
  localparam logic [ADDR_W-1:0] A_POL   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd5;

  localparam int MODE_W    = 4;
  localparam int STAT_FLAG = 1;
  localparam int STAT_CHG  = 2;

  typedef struct packed {
    logic     irq_match_only;
    pm_rule_e rule;
    logic     latch_en;
  } pm_mode_t;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= raw;
      cur    <= meta_q;
      prev   <= cur;
    end
  end
endmodule

// File: rtl/pm_bit_eval.sv
module pm_bit_eval #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] trans,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit,
  output logic [W-1:0] care
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic h;
    always_comb begin
      unique case ({mask[i], trans[i]})
        2'b00:   h = 1'b0;
        2'b01:   h = cur[i] ^ prev[i];
        2'b10:   h = ~(cur[i] ^ pol[i]);
        default: h = (cur[i] == pol[i]) && (prev[i] != pol[i]);
      endcase
    end
    assign hit[i]  = h;
    assign care[i] = mask[i] | trans[i];
  end
endmodule

// File: rtl/pm_combine.sv
module pm_combine
  import pm_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  hit,
  input  logic [W-1:0]  care,
  input  pm_rule_e      rule,
  output logic          match,
  output logic [IW-1:0] top_idx
);
  logic all_ok;
  logic any_ok;

  always_comb begin
    all_ok = (&(hit | ~care)) && (|care);
    any_ok = |(hit & care);
  end

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i] && care[i]) top_idx = i[IW-1:0];
    end
  end

  always_comb begin
    unique case (rule)
      RULE_ALL:  match = all_ok;
      RULE_ANY:  match = any_ok;
      RULE_PRIO: match = any_ok;
      default:   match = 1'b0;
    endcase
  end
endmodule

// File: rtl/pattern_match_unit.sv
module pattern_match_unit
  import pm_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          port_in,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [W-1:0]          wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [W-1:0]          rd_data,
  output logic                  match_flag,
  output logic                  irq,
  output logic [IW-1:0]         prio_idx
);
  // reset: asserted asynchronously, released synchronously
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [W-1:0] cur, prev, hit, care;
  logic         match;
  logic [IW-1:0] top_idx;

  pm_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .raw(port_in), .cur(cur), .prev(prev)
  );

  pm_mode_t     mode_q, mode_d;
  logic [W-1:0] mask_q, mask_d, trans_q, trans_d, pol_q, pol_d;
  logic         flag_q, flag_d, chg_q, chg_d;
  logic [W-1:0] hold_q, hold_d;
  logic         holding_q, holding_d;
  logic [IW-1:0] prio_q, prio_d;

  pm_bit_eval #(.W(W)) u_eval (
    .cur(cur), .prev(prev), .mask(mask_q), .trans(trans_q), .pol(pol_q),
    .hit(hit), .care(care)
  );

  pm_combine #(.W(W), .IW(IW)) u_comb (
    .hit(hit), .care(care), .rule(mode_q.rule), .match(match), .top_idx(top_idx)
  );

  logic wr_mode, wr_mask, wr_trans, wr_pol, wr_stat, data_rd, sample_chg;

  always_comb begin
    wr_mode    = wr_en && (wr_addr == A_MODE);
    wr_mask    = wr_en && (wr_addr == A_MASK);
    wr_trans   = wr_en && (wr_addr == A_TRANS);
    wr_pol     = wr_en && (wr_addr == A_POL);
    wr_stat    = wr_en && (wr_addr == A_STAT);
    data_rd    = rd_en && (rd_addr == A_DATA);
    sample_chg = |(cur ^ prev);
  end

  // next-state logic
  always_comb begin
    mode_d    = mode_q;
    mask_d    = mask_q;
    trans_d   = trans_q;
    pol_d     = pol_q;
    flag_d    = flag_q;
    chg_d     = chg_q;
    hold_d    = hold_q;
    holding_d = holding_q;
    prio_d    = prio_q;

    if (wr_mode)  mode_d  = pm_mode_t'(wr_data[MODE_W-1:0]);
    if (wr_mask)  mask_d  = wr_data;
    if (wr_trans) trans_d = wr_data;
    if (wr_pol)   pol_d   = wr_data;

    if (wr_stat && wr_data[STAT_FLAG]) flag_d = 1'b0;
    if (match)                         flag_d = 1'b1;
    if (wr_stat && wr_data[STAT_CHG])  chg_d  = 1'b0;
    if (sample_chg)                    chg_d  = 1'b1;

    if (data_rd) holding_d = 1'b0;
    if (mode_q.latch_en && match && (!holding_q || data_rd)) begin
      hold_d    = cur;
      holding_d = 1'b1;
    end

    if ((mode_q.rule == RULE_PRIO) && match) prio_d = top_idx;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q    <= '0;
      mask_q    <= '0;
      trans_q   <= '0;
      pol_q     <= '0;
      flag_q    <= 1'b0;
      chg_q     <= 1'b0;
      hold_q    <= '0;
      holding_q <= 1'b0;
      prio_q    <= '0;
    end else begin
      mode_q    <= mode_d;
      mask_q    <= mask_d;
      trans_q   <= trans_d;
      pol_q     <= pol_d;
      flag_q    <= flag_d;
      chg_q     <= chg_d;
      hold_q    <= hold_d;
      holding_q <= holding_d;
      prio_q    <= prio_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_MODE:  rd_data = {{(W-MODE_W){1'b0}}, mode_q};
      A_MASK:  rd_data = mask_q;
      A_TRANS: rd_data = trans_q;
      A_POL:   rd_data = pol_q;
      A_STAT: begin
        rd_data[STAT_FLAG] = flag_q;
        rd_data[STAT_CHG]  = chg_q;
      end
      A_DATA:  rd_data = holding_q ? hold_q : cur;
      default: rd_data = '0;
    endcase
  end

  assign match_flag = flag_q;
  assign irq        = flag_q | (chg_q & ~mode_q.irq_match_only);
  assign prio_idx   = prio_q;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [W-1:0]  wr_data,
  input logic          rd_en,
  input logic [2:0]    rd_addr,
  input logic          match_flag,
  input logic          irq,
  input logic [IW-1:0] prio_idx,
  input logic [3:0]    mode_q,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  trans_q,
  input logic          holding_q,
  input logic [W-1:0]  hold_q
);
  logic clr_req, rd_req;
  assign clr_req = wr_en && (wr_addr == 3'd4) && wr_data[1];
  assign rd_req  = rd_en && (rd_addr == 3'd5);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_req) |=> match_flag);

  a_r7_rule_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q[2:1] == 2'd0) && !match_flag) |=> !match_flag);

  a_r7_all_left_out: assert property (@(posedge clk) disable iff (!rst_n)
    (((mask_q | trans_q) == '0) && !match_flag) |=> !match_flag);

  a_r10_irq_match_only: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3] |-> (irq == match_flag));

  a_r6_prio_only_rule3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prio_idx) |-> ($past(mode_q[2:1]) == 2'd3));

  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (holding_q && !rd_req) |=> (holding_q && $stable(hold_q)));
endmodule

bind pattern_match_unit pm_checker #(.W(W), .IW(IW)) u_pm_checker (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
  .match_flag(match_flag), .irq(irq), .prio_idx(prio_idx),
  .mode_q(mode_q), .mask_q(mask_q), .trans_q(trans_q),
  .holding_q(holding_q), .hold_q(hold_q)
);

// File: tb/pattern_match_unit_tb_top.sv
`timescale 1ns/1ps
module pattern_match_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       match_flag, irq;
  logic [2:0] prio_idx;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pattern_match_unit dut_i (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .match_flag(match_flag), .irq(irq), .prio_idx(prio_idx)
  );

  // behavioural reference
  logic [7:0] samp[$];
  logic [7:0] b_mode, b_mask, b_tr, b_pol, b_hold;
  bit         b_flag, b_chg, b_holding;
  int         b_prio;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp = '{8'h00, 8'h00, 8'h00};
      b_mode = 0; b_mask = 0; b_tr = 0; b_pol = 0; b_hold = 0;
      b_flag = 0; b_chg = 0; b_holding = 0; b_prio = 0;
    end else begin
      logic [7:0] c, p;
      int ncare, nhold, top;
      bit mt, rel, nholding;
      c = samp[$-1]; p = samp[$-2];
      ncare = 0; nhold = 0; top = -1;
      for (int i = 0; i < 8; i++) begin
        bit ok;
        if (!b_mask[i] && !b_tr[i]) continue;
        ncare++;
        if (!b_mask[i])     ok = (c[i] != p[i]);
        else if (!b_tr[i])  ok = (c[i] == b_pol[i]);
        else                ok = (c[i] == b_pol[i]) && (p[i] != b_pol[i]);
        if (ok) begin nhold++; top = i; end
      end
      case (b_mode[2:1])
        2'd1:    mt = (ncare > 0) && (nhold == ncare);
        2'd2:    mt = (nhold > 0);
        2'd3:    mt = (nhold > 0);
        default: mt = 0;
      endcase
      if (wr_en && wr_addr == 3'd4 && wr_data[1]) b_flag = 0;
      if (mt) b_flag = 1;
      if (wr_en && wr_addr == 3'd4 && wr_data[2]) b_chg = 0;
      if (c != p) b_chg = 1;
      rel = rd_en && (rd_addr == 3'd5);
      nholding = b_holding;
      if (rel) nholding = 0;
      if (b_mode[0] && mt && (!b_holding || rel)) begin b_hold = c; nholding = 1; end
      b_holding = nholding;
      if (b_mode[2:1] == 2'd3 && mt) b_prio = top;
      if (wr_en) case (wr_addr)
        3'd0: b_mode = {4'h0, wr_data[3:0]};
        3'd1: b_mask = wr_data;
        3'd2: b_tr   = wr_data;
        3'd3: b_pol  = wr_data;
        default: ;
      endcase
      samp.push_back(port_in);
      void'(samp.pop_front());
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return b_mode;
      3'd1: return b_mask;
      3'd2: return b_tr;
      3'd3: return b_pol;
      3'd4: return {5'd0, b_chg, b_flag, 1'b0};
      3'd5: return b_holding ? b_hold : samp[$-1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(match_flag == b_flag, "R9 flag vs model", match_flag, b_flag);
      chk(irq == (b_flag | (b_chg & ~b_mode[3])), "R10 irq vs model", irq,
          b_flag | (b_chg & ~b_mode[3]));
      chk(prio_idx == b_prio[2:0], "R6 prio vs model", prio_idx, b_prio);
      chk(rd_data == exp_rd(rd_addr), "R11 rd_data vs model", rd_data, exp_rd(rd_addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic setp(input logic [7:0] v);
    @(negedge clk); port_in = v;
  endtask
  task automatic clr();
    wr(3'd4, 8'h06);
  endtask
  task automatic cfg(input logic [7:0] m, input logic [7:0] mk,
                     input logic [7:0] t, input logic [7:0] pl);
    wr(3'd1, mk); wr(3'd2, t); wr(3'd3, pl); wr(3'd0, m);
  endtask
  task automatic rdchk(input logic [2:0] a, input logic [7:0] e, input string req);
    @(negedge clk); rd_en = 1; rd_addr = a; #2;
    chk(rd_data == e, req, rd_data, e);
    @(negedge clk); rd_en = 0; rd_addr = 3'd0;
  endtask
  task automatic flagchk(input bit e, input string req);
    #2; chk(match_flag == e, req, match_flag, e);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(4);
    // R1 reset state
    #2;
    chk(match_flag == 0 && irq == 0, "R1 flag/irq after reset", {match_flag, irq}, 0);
    chk(prio_idx == 0, "R1 prio after reset", prio_idx, 0);
    rdchk(3'd1, 8'h00, "R1 mask reads 0");
    rdchk(3'd4, 8'h00, "R1 status reads 0");

    // R2 level codes, left-out bits ignored
    cfg(8'h0C, 8'h01, 8'h00, 8'h01); clr(); idle(3);
    flagchk(0, "R2 high level not yet present");
    setp(8'h01); idle(4); flagchk(1, "R2 high level matched");
    #2; chk(irq == 1, "R10 irq follows flag", irq, 1);
    clr(); idle(2); flagchk(1, "R9 match wins over clear");
    setp(8'h00); idle(4); clr(); idle(3); flagchk(0, "R9 clear takes effect");
    setp(8'hFE); idle(4); flagchk(0, "R2 left-out bits ignored");
    wr(3'd3, 8'h00); idle(3); flagchk(1, "R2 low level matched");

    // R3 edges
    setp(8'h00); cfg(8'h0C, 8'h80, 8'h80, 8'h00); idle(4); clr(); idle(2);
    setp(8'h80); idle(4); flagchk(0, "R3 rising ignored by falling code");
    setp(8'h00); idle(4); flagchk(1, "R3 falling edge matched");
    wr(3'd3, 8'h80); clr();
    setp(8'h80); idle(4); flagchk(1, "R3 rising edge matched");
    clr(); idle(4); flagchk(0, "R3 edge counts once");
    cfg(8'h0C, 8'h00, 8'h02, 8'h00); clr(); idle(2);
    setp(8'h82); idle(4); flagchk(1, "R3 any change matched");

    // R4 AND rule
    cfg(8'h0A, 8'h03, 8'h00, 8'h03); setp(8'h01); idle(4); clr(); idle(3);
    flagchk(0, "R4 partial pattern rejected");
    setp(8'h03); idle(4); flagchk(1, "R4 full pattern matched");
    wr(3'd2, 8'h01); setp(8'h02); idle(4); clr(); idle(3);
    flagchk(0, "R4 level without edge rejected");
    setp(8'h03); idle(4); flagchk(1, "R4 edge and level together matched");

    // R5 OR rule
    cfg(8'h0C, 8'h03, 8'h00, 8'h03); setp(8'h00); idle(4); clr(); idle(3);
    flagchk(0, "R5 no bit holds");
    setp(8'h02); idle(4); flagchk(1, "R5 one bit suffices");

    // R7 disabled rule and all bits left out
    cfg(8'h08, 8'hFF, 8'h00, 8'hFF); setp(8'hFF); idle(4); clr(); idle(3);
    flagchk(0, "R7 rule 0 never matches");
    cfg(8'h0A, 8'h00, 8'h00, 8'h00); clr();
    setp(8'h00); idle(3); setp(8'h55); idle(4); flagchk(0, "R7 all left out never matches");

    // R6 priority rule
    cfg(8'h0E, 8'h0F, 8'h00, 8'h0F); setp(8'h00); idle(4); clr(); idle(2);
    setp(8'h05); idle(4); flagchk(1, "R6 match in rule 3");
    #2; chk(prio_idx == 3'd2, "R6 highest bit 2", prio_idx, 2);
    setp(8'h0D); idle(4); #2; chk(prio_idx == 3'd3, "R6 highest bit 3", prio_idx, 3);

    // R8 latch on match
    cfg(8'h0D, 8'h01, 8'h01, 8'h01); setp(8'h00); idle(4);
    rdchk(3'd5, 8'h00, "R8 live data before match"); clr(); idle(2);
    setp(8'h41); idle(4); setp(8'h20); idle(4);
    rdchk(3'd5, 8'h41, "R8 held value returned");
    rdchk(3'd5, 8'h20, "R8 hold released after read");

    // R10 change flag drives irq without match-only
    cfg(8'h04, 8'h00, 8'h00, 8'h00); clr(); idle(2);
    setp(8'h77); idle(4);
    #2; chk(irq == 1 && match_flag == 0, "R10 change raises irq", {irq, match_flag}, 2);
    rdchk(3'd4, 8'h04, "R10 status change bit");
    rdchk(3'd0, 8'h04, "R11 mode readback");
    clr(); idle(2); #2; chk(irq == 0, "R10 irq drops after clear", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule